// File: doc/BRIEF.md
# High-Voltage Mode Decoding EPROM Model

This block is a synthesizable, clocked behavioural model of a 16-bit-wide electrically erasable read-only memory. It exists for system models and test fixtures: a host drives the memory's pins (active-low chip select and output gate, an address bus, and a data bus split into input, output and output-drive-enable) and gets a faithful picture of the part's operating modes. Pins that would carry a high voltage are abstracted as two-bit level codes, one for the programming supply and one for address bit 9.

From the enables and the level codes the block picks a mode each cycle. The mode set covers read, output off, standby, word programming, whole-array erase, margin verify, write inhibit and identifier read. A program or erase is committed once per chip-select pulse: either on the clock edge where chip select is first seen high again, or after a fixed number of clocks with chip select held low. The storage array is kept small through a parameter; only the low address bits index it.

The memory pins are plain level pins sampled on the clock, with no valid/ready handshake. A real part has no way to stall its host, so the bus carries no back-pressure.

Top module: `eprom_mode_model`

## Requirements
- R1: With chip select low, output gate low and the supply level normal (code 0 or 3) and address-9 level not 1, `dq_oe` is 1 and `dq_out` shows the word at `addr[ARR_AW-1:0]`.
- R2: With chip select low, output gate high and a normal supply level, `dq_oe` is 0, `dq_out` is 0, and nothing is written.
- R3: With chip select high and a normal supply level, `dq_oe` is 0 whatever the output gate is.
- R4: With chip select low, output gate high and supply level 1 (program), the committed write stores old AND `dq_in` at the addressed word. No write ever turns a 0 bit into a 1.
- R5: With chip select low, output gate high, supply level 2, address-9 level 2, all address bits other than bit 9 zero and `dq_in` all ones, the committed operation sets every word to all ones.
- R6: An erase-level request with chip select low and output gate high, but with any other condition of R5 unmet, changes no word and leaves `dq_oe` 0.
- R7: With chip select high, output gate low and supply level 1 or 2, `dq_oe` is 1 and `dq_out` shows the addressed word.
- R8: With chip select high, output gate high and supply level 1 or 2, `dq_oe` is 0 and nothing is written.
- R9: With both selects low, a normal supply and address-9 level 1, `dq_oe` is 1 and `dq_out` is 0x00DA when `addr[0]`=0 and 0x000D when `addr[0]`=1.
- R10: One chip-select-low pulse commits at most one write. The commit happens on the first edge where chip select is high after a write-mode cycle, or on the PULSE_CYC-th consecutive write-mode edge, whichever comes first. Leaving write mode with chip select still low abandons the operation.
- R11: After reset every word reads 0xFFFF.
- R12: Chip select low and output gate low with supply level 1 or 2 is a conflict: `dq_oe` is 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_lvl | input | 2 | Supply level code: 0 normal, 1 program, 2 erase, 3 normal |
| a9_lvl | input | 2 | Address-9 level code, same encoding |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Data bus, inbound |
| dq_out | output | DATA_W | Data bus, outbound (0 when not driven) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Programming runs twice on the same word with overlapping patterns, so stored AND semantics can be told apart from plain overwrite. One program pulse is ended by chip select rising and another by the clock count. In the counted case the data changes after the timeout, which separates a single commit from repeated commits, and a pulse that leaves write mode with chip select still low shows abandonment. Erase requests are tried with an odd address, with data not all ones and with address 9 at the wrong level before the valid one, to show that only the exact pattern clears the array. Verify, inhibit, conflict, standby and both identifier addresses are compared every cycle against a behavioural reference array.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [1:0] {
    LVL_NORMAL = 2'd0,
    LVL_PROG   = 2'd1,
    LVL_ERASE  = 2'd2,
    LVL_RSVD   = 2'd3
  } hv_level_e;

  typedef enum logic [3:0] {
    M_STANDBY,
    M_READ,
    M_OUT_OFF,
    M_IDENT,
    M_PROGRAM,
    M_ERASE,
    M_ERASE_REJ,
    M_VERIFY,
    M_INHIBIT,
    M_CONFLICT
  } op_mode_e;

  localparam logic [15:0] MAKER_CODE  = 16'h00DA;
  localparam logic [15:0] DEVICE_CODE = 16'h000D;
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [1:0]        vpp_lvl,
  input  logic [1:0]        a9_lvl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output op_mode_e          mode
);
  localparam logic [ADDR_W-1:0] NOT_A9 = ~(ADDR_W'(1) << 9);

  logic vpp_high;
  logic erase_pattern;

  always_comb begin
    vpp_high      = (vpp_lvl == LVL_PROG) || (vpp_lvl == LVL_ERASE);
    erase_pattern = (a9_lvl == LVL_ERASE) && ((addr & NOT_A9) == '0) && (&dq_in);
    if (ce_n) begin
      if (!vpp_high)   mode = M_STANDBY;
      else if (!oe_n)  mode = M_VERIFY;
      else             mode = M_INHIBIT;
    end else if (!vpp_high) begin
      if (oe_n)                       mode = M_OUT_OFF;
      else if (a9_lvl == LVL_PROG)    mode = M_IDENT;
      else                            mode = M_READ;
    end else if (!oe_n) begin
      mode = M_CONFLICT;
    end else if (vpp_lvl == LVL_PROG) begin
      mode = M_PROGRAM;
    end else if (erase_pattern) begin
      mode = M_ERASE;
    end else begin
      mode = M_ERASE_REJ;
    end
  end
endmodule

// File: rtl/eprom_write_seq.sv
module eprom_write_seq #(
  parameter int ARR_AW    = 6,
  parameter int DATA_W    = 16,
  parameter int PULSE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              want_prog,
  input  logic              want_erase,
  input  logic [ARR_AW-1:0] idx_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              prog_stb,
  output logic              erase_stb,
  output logic [ARR_AW-1:0] wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

  logic              wmode;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              pend_q;
  logic              pend_erase_q;
  logic [ARR_AW-1:0] pend_idx_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              timeout;
  logic              rise_fire;

  always_comb begin
    wmode     = want_prog || want_erase;
    timeout   = wmode && !done_q && (cnt_q == LAST);
    rise_fire = !timeout && ce_n && pend_q && !done_q;
    prog_stb  = (timeout && want_prog) || (rise_fire && !pend_erase_q);
    erase_stb = (timeout && want_erase) || (rise_fire && pend_erase_q);
    wr_idx    = timeout ? idx_in  : pend_idx_q;
    wr_data   = timeout ? data_in : pend_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      done_q       <= 1'b0;
      pend_q       <= 1'b0;
      pend_erase_q <= 1'b0;
      pend_idx_q   <= '0;
      pend_data_q  <= '0;
    end else begin
      if (!wmode)       cnt_q <= '0;
      else if (!done_q) cnt_q <= cnt_q + 1'b1;
      done_q       <= ce_n ? 1'b0 : (done_q || timeout);
      pend_q       <= wmode && !done_q && !timeout;
      pend_erase_q <= want_erase;
      pend_idx_q   <= idx_in;
      pend_data_q  <= data_in;
    end
  end

  assert_single_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |=> !(prog_stb || erase_stb));
  assert_commit_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, erase_stb}));
  assert_commit_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb || erase_stb) |-> (wmode || $past(wmode)));
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ARR_AW = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_stb,
  input  logic              erase_stb,
  input  logic [ARR_AW-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ARR_AW-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase_stb) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (prog_stb) begin
      cells[wr_idx] <= cells[wr_idx] & wr_data;
    end
  end

  assign rd_data = cells[rd_idx];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell_chk
    assert_no_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(erase_stb) |-> ((cells[gi] & ~$past(cells[gi])) == '0));
    assert_erase_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(erase_stb) |-> (&cells[gi]));
  end
endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int ARR_AW    = 6,
  parameter int PULSE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [1:0]        vpp_lvl,
  input  logic [1:0]        a9_lvl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  op_mode_e          mode;
  logic              prog_stb;
  logic              erase_stb;
  logic [ARR_AW-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic [ARR_AW-1:0] idx;

  assign idx = addr[ARR_AW-1:0];

  eprom_mode_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_lvl(vpp_lvl), .a9_lvl(a9_lvl),
    .addr(addr), .dq_in(dq_in), .mode(mode)
  );

  eprom_write_seq #(.ARR_AW(ARR_AW), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
    .want_prog(mode == M_PROGRAM), .want_erase(mode == M_ERASE),
    .idx_in(idx), .data_in(dq_in),
    .prog_stb(prog_stb), .erase_stb(erase_stb),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  eprom_cell_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_stb(prog_stb), .erase_stb(erase_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(idx), .rd_data(rd_data)
  );

  always_comb begin
    dq_oe  = 1'b0;
    dq_out = '0;
    case (mode)
      M_READ, M_VERIFY: begin
        dq_oe  = 1'b1;
        dq_out = rd_data;
      end
      M_IDENT: begin
        dq_oe  = 1'b1;
        dq_out = addr[0] ? DATA_W'(DEVICE_CODE) : DATA_W'(MAKER_CODE);
      end
      default: ;
    endcase
  end

  assert_out_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && vpp_lvl != LVL_PROG && vpp_lvl != LVL_ERASE) |-> (!dq_oe && dq_out == '0));
  assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && vpp_lvl != LVL_PROG && vpp_lvl != LVL_ERASE) |-> !dq_oe);
  assert_no_write_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n && $past(ce_n)) |-> !(prog_stb || erase_stb));
  assert_conflict_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && (vpp_lvl == LVL_PROG || vpp_lvl == LVL_ERASE)) |-> !dq_oe);
endmodule

// File: tb/test_eprom_mode_model.sv
module test_eprom_mode_model;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int CAW = 6;
  localparam int PC = 8;
  localparam int DEPTH = 1 << CAW;
  localparam logic [1:0] NRM = 2'd0, PRG = 2'd1, ERS = 2'd2, RSV = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [1:0] vpp_lvl = NRM, a9_lvl = NRM;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  int  r_cnt;
  bit  r_done, r_pend, r_pend_erase;
  int  r_pidx;
  logic [DW-1:0] r_pdata;

  always #4 clk = ~clk;

  eprom_mode_model #(.ADDR_W(AW), .DATA_W(DW), .ARR_AW(CAW), .PULSE_CYC(PC)) i_eprom_mode_model (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_lvl(vpp_lvl),
    .a9_lvl(a9_lvl), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit hv(input logic [1:0] l);
    return l == PRG || l == ERS;
  endfunction

  // 0 none, 1 program, 2 erase
  function automatic int write_kind();
    if (ce_n || oe_n !== 1'b1 || !hv(vpp_lvl)) return 0;
    if (vpp_lvl == PRG) return 1;
    if (a9_lvl == ERS && dq_in == 16'hFFFF && (addr & ~(18'd1 << 9)) == 0) return 2;
    return 0;
  endfunction

  task automatic apply_commit(input bit is_erase, input int idx, input logic [DW-1:0] d);
    if (is_erase) for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    else ref_mem[idx] = ref_mem[idx] & d;
  endtask

  task automatic model_edge();
    int wk;
    bit tmo;
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
      r_cnt = 0; r_done = 0; r_pend = 0; r_pend_erase = 0; r_pidx = 0; r_pdata = 0;
      return;
    end
    wk  = write_kind();
    tmo = (wk != 0) && !r_done && (r_cnt == PC - 1);
    if (tmo) apply_commit(wk == 2, int'(addr[CAW-1:0]), dq_in);
    else if (ce_n && r_pend && !r_done) apply_commit(r_pend_erase, r_pidx, r_pdata);
    if (wk == 0) r_cnt = 0; else if (!r_done) r_cnt++;
    r_pend = (wk != 0) && !r_done && !tmo;
    r_done = ce_n ? 0 : (r_done || tmo);
    r_pend_erase = (wk == 2);
    r_pidx = int'(addr[CAW-1:0]);
    r_pdata = dq_in;
  endtask

  task automatic compare_all();
    logic en;
    logic [DW-1:0] d;
    string tag;
    en = 0; d = 0; tag = "R2";
    if (ce_n) begin
      if (!hv(vpp_lvl)) tag = "R3";
      else if (!oe_n) begin en = 1; d = ref_mem[addr[CAW-1:0]]; tag = "R7"; end
      else tag = "R8";
    end else if (!hv(vpp_lvl)) begin
      if (!oe_n && a9_lvl == PRG) begin en = 1; d = addr[0] ? 16'h000D : 16'h00DA; tag = "R9"; end
      else if (!oe_n) begin en = 1; d = ref_mem[addr[CAW-1:0]]; tag = "R1"; end
    end else if (!oe_n) tag = "R12";
    else tag = (vpp_lvl == PRG) ? "R4" : "R6";
    chk({tag, " oe"}, {31'd0, dq_oe}, {31'd0, en});
    chk({tag, " data"}, {16'd0, dq_out}, {16'd0, d});
  endtask

  task automatic cyc(input logic c, input logic o, input logic [1:0] vp, input logic [1:0] a9,
                     input int ad, input logic [DW-1:0] d);
    ce_n = c; oe_n = o; vpp_lvl = vp; a9_lvl = a9; addr = AW'(ad); dq_in = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input int ad);
    cyc(0, 0, NRM, NRM, ad, 16'h0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin @(posedge clk); model_edge(); end
    @(negedge clk);
    rst_n = 1'b1;
    // R11: erased after reset
    rd(0);  chk("R11", dq_out, 16'hFFFF);
    rd(63); chk("R11", dq_out, 16'hFFFF);
    rd(5);  chk("R1", dq_oe, 1'b1);
    // R4: program via chip-select rise, then overlap pattern
    for (int i = 0; i < 3; i++) cyc(0, 1, PRG, NRM, 5, 16'h1234);
    cyc(1, 1, NRM, NRM, 5, 16'h0);
    rd(5); chk("R4", dq_out, 16'h1234);
    for (int i = 0; i < 2; i++) cyc(0, 1, PRG, NRM, 5, 16'hFF0F);
    cyc(1, 1, NRM, NRM, 5, 16'h0);
    rd(5); chk("R4", dq_out, 16'h1204);
    // R10: held low past the pulse count, data changes later
    for (int i = 0; i < 10; i++) cyc(0, 1, PRG, NRM, 7, 16'h00F0);
    for (int i = 0; i < 6; i++)  cyc(0, 1, PRG, NRM, 7, 16'h0000);
    cyc(1, 1, NRM, NRM, 7, 16'h0);
    rd(7); chk("R10", dq_out, 16'h00F0);
    // R10/R12: leave write mode with chip select low -> abandoned
    for (int i = 0; i < 2; i++) cyc(0, 1, PRG, NRM, 9, 16'h0000);
    cyc(0, 0, PRG, NRM, 9, 16'h0000);
    chk("R12", dq_oe, 1'b0);
    cyc(1, 1, NRM, NRM, 9, 16'h0);
    rd(9); chk("R10", dq_out, 16'hFFFF);
    // R7 verify at both levels, R8 inhibit
    cyc(1, 0, PRG, NRM, 5, 16'h0); chk("R7", dq_out, 16'h1204);
    cyc(1, 0, ERS, NRM, 7, 16'h0); chk("R7", dq_out, 16'h00F0);
    for (int i = 0; i < 12; i++) cyc(1, 1, PRG, NRM, 11, 16'h0000);
    chk("R8", dq_oe, 1'b0);
    rd(11); chk("R8", dq_out, 16'hFFFF);
    // R9 identifier
    cyc(0, 0, NRM, PRG, 0, 16'h0); chk("R9", dq_out, 16'h00DA);
    cyc(0, 0, NRM, PRG, 1, 16'h0); chk("R9", dq_out, 16'h000D);
    // R2 output off, R3 standby with gate low, reserved code as normal
    cyc(0, 1, NRM, NRM, 5, 16'h0000); chk("R2", dq_oe, 1'b0);
    cyc(1, 0, NRM, NRM, 5, 16'h0);    chk("R3", dq_oe, 1'b0);
    cyc(1, 0, RSV, NRM, 5, 16'h0);    chk("R3", dq_oe, 1'b0);
    rd(5); chk("R2", dq_out, 16'h1204);
    // R6 rejected erase patterns
    for (int i = 0; i < 3; i++) cyc(0, 1, ERS, ERS, 1, 16'hFFFF);
    cyc(1, 1, NRM, NRM, 0, 16'h0);
    for (int i = 0; i < 3; i++) cyc(0, 1, ERS, ERS, 0, 16'hFFFE);
    cyc(1, 1, NRM, NRM, 0, 16'h0);
    for (int i = 0; i < 3; i++) cyc(0, 1, ERS, NRM, 0, 16'hFFFF);
    cyc(1, 1, NRM, NRM, 0, 16'h0);
    rd(5); chk("R6", dq_out, 16'h1204);
    // R5 valid erase (address bit 9 logic level set, still accepted)
    for (int i = 0; i < 3; i++) cyc(0, 1, ERS, ERS, 512, 16'hFFFF);
    cyc(1, 1, NRM, NRM, 0, 16'h0);
    rd(5); chk("R5", dq_out, 16'hFFFF);
    rd(7); chk("R5", dq_out, 16'hFFFF);
    rd(1); rd(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule